// File: doc/BRIEF.md
# Stop-Mode Oscillation Stabilization Timer

This block governs the low-power halt and wake-up sequence of a small processor core. A halt request freezes the oscillator-side logic and gates the core clock off. A light-sleep request only gates the core clock, and the oscillator-side counting keeps running. An interrupt request ends either condition. Leaving a halt does not hand the clock back at once. An 8-bit prescaler and an 8-bit timer first count down a stabilization delay. The core clock enable returns only when that timer underflows.

By default, entering a halt presets the prescaler to 0xFF and the timer to 0x01. With the default count source this gives 512 count-source ticks of settling. A control input can suppress that preset. Software then programs its own delay through the normal write port before it issues the halt. Reset takes the same preset path and the same settling wait as a halt. The count source is a power-of-two division of the oscillator clock. The selection made before a halt stays in force through the halt and its settling period.

Top module: `osc_stab_timer`

## Requirements
- R1: While reset is asserted and after its release, `clk_en` is 0, `presc_q` is 0xFF and `timer_q` is 0x01. The count source is then divide-by-16 (`src_sel` code 2'b11), and `clk_en` rises after 512 count-source ticks.
- R2: A `stop_req` sampled while `clk_en` is 1 and `no_preset` is 0 makes `clk_en` 0 from the next cycle. It also sets `presc_q` to 0xFF and `timer_q` to 0x01.
- R3: A `stop_req` sampled while `no_preset` is 1 leaves the counters unchanged. If a counter write is sampled in the same cycle, the counters take the written values.
- R4: While halted, `presc_q`, `timer_q` and `clk_en` (=0) hold until `irq_req` is seen. The `irq_dis` flag does not prevent that wake-up.
- R5: After the waking interrupt, `clk_en` stays 0 until the timer underflows. Starting from prescaler P and timer T, this takes P+1+256*T count-source ticks.
- R6: Count-source codes are 2'b00=/2, 2'b01=/4, 2'b10=/8 and 2'b11=/16. `src_wr` loads `src_sel` only while `clk_en` is 1 and is ignored during a halt or during settling.
- R7: A `wait_req` sampled while `clk_en` is 1 makes `clk_en` 0 from the next cycle while the counters keep counting. A following `irq_req` restores `clk_en` in the next cycle with no settling delay.
- R8: A `stop_req` is ignored while `clk_en` is 0 (during settling or light sleep). After settling ends, `clk_en` stays 1.
- R9: `tmr_wr` loads `presc_wdata` and `timer_wdata` only while `clk_en` is 1 and is ignored during a halt.
- R10: An `irq_req` while `clk_en` is 1 has no effect on `clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Halt request (oscillator-side logic frozen) |
| wait_req | input | 1 | Light-sleep request (clock gated only) |
| irq_req | input | 1 | Interrupt request, wakes from halt or sleep |
| irq_dis | input | 1 | Interrupt-disable flag, no effect on wake-up |
| no_preset | input | 1 | 1: a halt leaves prescaler and timer untouched |
| src_wr | input | 1 | Load strobe for the count-source selection |
| src_sel | input | 2 | Count-source divide code |
| tmr_wr | input | 1 | Load strobe for prescaler and timer |
| presc_wdata | input | 8 | Prescaler write value |
| timer_wdata | input | 8 | Timer write value |
| clk_en | output | 1 | Core clock enable |
| presc_q | output | 8 | Prescaler count |
| timer_q | output | 8 | Timer count |

## Verification
Most faults in the halt or settling state show at the ports within one cycle, as a wrong `clk_en` level. A halt flag that does not clear keeps `clk_en` low until the run ends. A settling flag that clears too early shows as a release time outside the tick window worked out from P, T and the divide ratio. A wrong preset or a count source that does not hold shows either at once on `presc_q`/`timer_q` or as a release that comes hundreds of cycles off. So every wake-up is timed against a window of one divide period.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;
  localparam int unsigned SRC_SEL_W = 2;
  localparam int unsigned CNT_BITS  = 8;

  typedef enum logic [SRC_SEL_W-1:0] {
    SRC_DIV2  = 2'b00,
    SRC_DIV4  = 2'b01,
    SRC_DIV8  = 2'b10,
    SRC_DIV16 = 2'b11
  } src_code_e;

  typedef struct packed {
    logic halted;
    logic sleeping;
    logic settling;
  } pwr_state_t;
endpackage

// File: rtl/osc_rst_sync.sv
module osc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/osc_src_div.sv
module osc_src_div
  import osc_stab_pkg::*;
#(
  parameter int unsigned SEL_W = SRC_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_run,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_in,
  output logic             tick
);
  localparam int unsigned DIV_W = 1 << SEL_W;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i <= int'(sel_q));
    end
  end

  always_comb begin
    sel_d = sel_q;
    if (sel_wr) sel_d = sel_in;
    div_d = div_q;
    if (osc_run) div_d = div_q + 1'b1;
  end

  assign tick = osc_run && (&(div_q | ~mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '1;
      div_q <= '0;
    end else begin
      sel_q <= sel_d;
      div_q <= div_d;
    end
  end

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));

  // R4
  div_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |=> $stable(div_q));
endmodule

// File: rtl/osc_stab_cnt.sv
module osc_stab_cnt #(
  parameter int unsigned          PW     = 8,
  parameter int unsigned          TW     = 8,
  parameter logic [PW-1:0]        P_PRE  = 8'hFF,
  parameter logic [TW-1:0]        T_PRE  = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          preset_ld,
  input  logic          sw_wr,
  input  logic [PW-1:0] sw_presc,
  input  logic [TW-1:0] sw_timer,
  input  logic          tick,
  output logic [PW-1:0] presc_q,
  output logic [TW-1:0] timer_q,
  output logic          tmr_unf
);
  logic [PW-1:0] presc_d;
  logic [TW-1:0] timer_d;
  logic          presc_unf;

  assign presc_unf = tick && (presc_q == '0);
  assign tmr_unf   = presc_unf && (timer_q == '0);

  always_comb begin
    presc_d = presc_q;
    timer_d = timer_q;
    if (preset_ld) begin
      presc_d = P_PRE;
      timer_d = T_PRE;
    end else if (sw_wr) begin
      presc_d = sw_presc;
      timer_d = sw_timer;
    end else if (tick) begin
      presc_d = presc_q - 1'b1;
      if (presc_unf) timer_d = timer_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= P_PRE;
      timer_q <= T_PRE;
    end else begin
      presc_q <= presc_d;
      timer_q <= timer_d;
    end
  end

  // R2
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_ld |=> (presc_q == P_PRE) && (timer_q == T_PRE));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !preset_ld && !sw_wr) |=> $stable(presc_q) && $stable(timer_q));
endmodule

// File: rtl/osc_stop_ctrl.sv
module osc_stop_ctrl
  import osc_stab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wait_req,
  input  logic irq_req,
  input  logic irq_dis,
  input  logic no_preset,
  input  logic tmr_unf,
  output logic clk_en,
  output logic osc_run,
  output logic preset_ld
);
  pwr_state_t st_q, st_d;
  logic stop_acc, wait_acc;

  assign clk_en    = !(st_q.halted || st_q.sleeping || st_q.settling);
  assign osc_run   = !st_q.halted;
  assign stop_acc  = clk_en && stop_req;
  assign wait_acc  = clk_en && wait_req && !stop_req;
  assign preset_ld = stop_acc && !no_preset;

  always_comb begin
    st_d = st_q;
    if (st_q.halted && irq_req) begin
      st_d.halted   = 1'b0;
      st_d.settling = 1'b1;
    end else if (stop_acc) begin
      st_d.halted = 1'b1;
    end
    if (st_q.settling && tmr_unf) st_d.settling = 1'b0;
    if (st_q.sleeping && irq_req) st_d.sleeping = 1'b0;
    else if (wait_acc)            st_d.sleeping = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.halted   <= 1'b0;
      st_q.sleeping <= 1'b0;
      st_q.settling <= 1'b1;
    end else begin
      st_q <= st_d;
    end
  end

  // R2
  stop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && stop_req) |=> (!clk_en && st_q.halted));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.halted && !irq_req) |=> st_q.halted);

  // R4
  wake_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.halted && irq_req && irq_dis) |=> !st_q.halted);

  // R5
  wake_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.halted && irq_req) |=> (st_q.settling && !clk_en));

  // R5
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.settling && !tmr_unf) |=> st_q.settling);

  // R7
  sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.sleeping && irq_req && !st_q.settling && !st_q.halted) |=> clk_en);
endmodule

// File: rtl/osc_stab_timer.sv
module osc_stab_timer
  import osc_stab_pkg::*;
#(
  parameter int unsigned            SEL_W  = SRC_SEL_W,
  parameter int unsigned            PW     = CNT_BITS,
  parameter int unsigned            TW     = CNT_BITS,
  parameter logic [CNT_BITS-1:0]    P_PRE  = 8'hFF,
  parameter logic [CNT_BITS-1:0]    T_PRE  = 8'h01,
  parameter int unsigned            SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             wait_req,
  input  logic             irq_req,
  input  logic             irq_dis,
  input  logic             no_preset,
  input  logic             src_wr,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             tmr_wr,
  input  logic [PW-1:0]    presc_wdata,
  input  logic [TW-1:0]    timer_wdata,
  output logic             clk_en,
  output logic [PW-1:0]    presc_q,
  output logic [TW-1:0]    timer_q
);
  logic rst_n_s;
  logic osc_run, preset_ld, tick, tmr_unf;
  logic src_wr_ok, tmr_wr_ok;

  assign src_wr_ok = src_wr && clk_en;
  assign tmr_wr_ok = tmr_wr && clk_en;

  osc_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  osc_src_div #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n_s), .osc_run(osc_run),
    .sel_wr(src_wr_ok), .sel_in(src_sel), .tick(tick)
  );

  osc_stab_cnt #(.PW(PW), .TW(TW), .P_PRE(P_PRE[PW-1:0]), .T_PRE(T_PRE[TW-1:0])) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .preset_ld(preset_ld), .sw_wr(tmr_wr_ok),
    .sw_presc(presc_wdata), .sw_timer(timer_wdata), .tick(tick),
    .presc_q(presc_q), .timer_q(timer_q), .tmr_unf(tmr_unf)
  );

  osc_stop_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .stop_req(stop_req), .wait_req(wait_req),
    .irq_req(irq_req), .irq_dis(irq_dis), .no_preset(no_preset),
    .tmr_unf(tmr_unf), .clk_en(clk_en), .osc_run(osc_run), .preset_ld(preset_ld)
  );

  // R9
  wr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!clk_en && !osc_run && tmr_wr) |=> ($stable(presc_q) && $stable(timer_q)));

  // R10
  irq_run_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clk_en && irq_req && !stop_req && !wait_req) |=> clk_en);
endmodule

// File: tb/osc_stab_timer_tb_top.sv
module osc_stab_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, wait_req = 0, irq_req = 0, irq_dis = 0, no_preset = 0;
  logic src_wr = 0, tmr_wr = 0;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] presc_wdata = 0, timer_wdata = 0;
  logic clk_en;
  logic [7:0] presc_q, timer_q;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  osc_stab_timer dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .irq_req(irq_req), .irq_dis(irq_dis), .no_preset(no_preset),
    .src_wr(src_wr), .src_sel(src_sel), .tmr_wr(tmr_wr),
    .presc_wdata(presc_wdata), .timer_wdata(timer_wdata),
    .clk_en(clk_en), .presc_q(presc_q), .timer_q(timer_q)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_range(input string tag, input int v, input int lo, input int hi);
    chk(v >= lo && v <= hi, tag, v, lo);
  endtask

  // Count edges after the current negedge until clk_en reads 1.
  task automatic measure(output int n);
    n = 0;
    while (clk_en == 1'b0 && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_irq();
    irq_req = 1; @(negedge clk); irq_req = 0;
  endtask

  task automatic set_src(input logic [1:0] code);
    src_sel = code; src_wr = 1; @(negedge clk); src_wr = 0;
  endtask

  task automatic t_reset();
    int n;
    chk(clk_en == 0, "R1 clk_en in reset", clk_en, 0);
    chk(presc_q == 8'hFF, "R1 presc in reset", presc_q, 255);
    chk(timer_q == 8'h01, "R1 timer in reset", timer_q, 1);
    rst_n = 1;
    measure(n);
    chk_range("R1 reset settle /16", n, 511*16 + 1, 512*16 + 6);
  endtask

  task automatic t_stop_preset();
    int n;
    set_src(2'b00);
    no_preset = 0; stop_req = 1; @(negedge clk); stop_req = 0;
    chk(clk_en == 0, "R2 clk_en after stop", clk_en, 0);
    chk(presc_q == 8'hFF, "R2 presc preset", presc_q, 255);
    chk(timer_q == 8'h01, "R2 timer preset", timer_q, 1);
    repeat (40) @(negedge clk);
    chk(presc_q == 8'hFF && timer_q == 8'h01, "R4 hold in stop", presc_q, 255);
    chk(clk_en == 0, "R4 clk_en held", clk_en, 0);
    // R9: write during halt ignored
    presc_wdata = 8'h55; timer_wdata = 8'h22; tmr_wr = 1; @(negedge clk); tmr_wr = 0;
    @(negedge clk);
    chk(presc_q == 8'hFF, "R9 write ignored in stop", presc_q, 255);
    irq_dis = 1;
    pulse_irq();
    irq_dis = 0;
    measure(n);
    chk_range("R5 default settle /2 (R4 wake with irq_dis)", n, 511*2 + 1, 512*2);
  endtask

  task automatic t_no_preset_freeze();
    int n;
    no_preset = 1;
    presc_wdata = 8'd3; timer_wdata = 8'd0; tmr_wr = 1; stop_req = 1;
    @(negedge clk);
    tmr_wr = 0; stop_req = 0;
    chk(presc_q == 8'd3, "R3 presc kept", presc_q, 3);
    chk(timer_q == 8'd0, "R3 timer kept", timer_q, 0);
    set_src(2'b11); // R6: must be ignored while halted
    pulse_irq();
    measure(n);
    chk_range("R6 source frozen, R5 short settle", n, 3*2 + 1, 4*2);
  endtask

  task automatic t_div8();
    int n;
    set_src(2'b10);
    no_preset = 1;
    presc_wdata = 8'd9; timer_wdata = 8'd0; tmr_wr = 1; stop_req = 1;
    @(negedge clk);
    tmr_wr = 0; stop_req = 0;
    pulse_irq();
    measure(n);
    chk_range("R6 divide by 8", n, 9*8 + 1, 10*8);
  endtask

  task automatic t_timer_nonzero();
    int n;
    set_src(2'b00);
    no_preset = 1;
    presc_wdata = 8'd0; timer_wdata = 8'd2; tmr_wr = 1; stop_req = 1;
    @(negedge clk);
    tmr_wr = 0; stop_req = 0;
    pulse_irq();
    // R8: stop during settling ignored
    stop_req = 1; @(negedge clk); stop_req = 0;
    measure(n);
    chk_range("R5 P=0 T=2 settle", n, 512*2 + 1 - 2, 513*2);
    repeat (3) @(negedge clk);
    chk(clk_en == 1, "R8 stop ignored in settle", clk_en, 1);
    no_preset = 0;
  endtask

  task automatic t_wait();
    logic [7:0] p0;
    p0 = presc_q;
    wait_req = 1; @(negedge clk); wait_req = 0;
    chk(clk_en == 0, "R7 clk_en in sleep", clk_en, 0);
    stop_req = 1; @(negedge clk); stop_req = 0; // R8: ignored in sleep
    repeat (20) @(negedge clk);
    chk(presc_q != p0, "R7 counting in sleep", presc_q, p0);
    pulse_irq();
    chk(clk_en == 1, "R7 immediate wake / R8", clk_en, 1);
  endtask

  task automatic t_irq_run();
    pulse_irq();
    @(negedge clk);
    chk(clk_en == 1, "R10 irq while running", clk_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_stop_preset();
    t_no_preset_freeze();
    t_div8();
    t_timer_nonzero();
    t_wait();
    t_irq_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule